// File: doc/BRIEF.md
# Slave-Parallel Configuration Loader

This block pushes a configuration bitstream into an FPGA's byte-wide slave configuration port. Bytes arrive from an upstream valid/ready source. The loader turns each accepted byte into one configuration-clock period. It drives the configuration clock, an active-low select, an active-low write line and an 8-bit data bus. One pulse on `startReq` pulls select and write low together. The loader then sends a fixed 32-bit synchronization word as four bytes, most significant byte first. After that it forwards exactly `byteTotal` data bytes. When the count is used up it raises `done` and releases select and write.

The port must never see the write line change level while select stays low across successive configuration clocks, except as a deliberate abort. To honour that rule, a stall of the upstream source only parks the configuration clock low. Select and write stay where they are.

An abort request makes the loader flip write high while select is still low, and give exactly one configuration-clock pulse in that state. It then lets go of the port and returns to idle. The next `startReq` begins again with the synchronization word, so the target can resynchronize before new data arrives.

Top module: `slave_cfg_loader`

## Requirements
- R1: After reset, and in idle, `cfgCsN` and `cfgWrN` are 1, `cfgClk` is 0, `inReady` is 0 and `done` is 0.
- R2: A `startReq` taken in idle or done drives `cfgCsN` and `cfgWrN` low in the same cycle. Both stay low until `done` rises or an abort begins.
- R3: The first four rising `cfgClk` edges after a start carry the bytes of `SYNC_WORD`, bits 31:24 first and bits 7:0 last, with `cfgCsN`=0 and `cfgWrN`=0.
- R4: Each upstream byte accepted with `inValid` and `inReady` both high appears on `cfgData` in the next cycle. It is written by exactly one later rising `cfgClk` edge, in acceptance order. `cfgData` never changes on the edge where `cfgClk` rises.
- R5: While no data is offered in the data phase, `cfgClk` stays low and `cfgCsN`/`cfgWrN` stay 0.
- R6: A `cfgClk` period lasts 2*`HALF_DIV` clock cycles. Sync bytes, and data offered without gaps, follow one another at that period.
- R7: Once `byteTotal` data bytes have been written, `done` goes to 1 and `cfgCsN`/`cfgWrN` return to 1. A total of zero writes only the sync word.
- R8: An `abortReq` seen in the sync or data phase beats any pending data. It produces one rising `cfgClk` with `cfgWrN`=1 and `cfgCsN`=0, accepts no further byte, then releases `cfgCsN` and goes idle with `done`=0.
- R9: A start after an abort sends the full sync word again before any data.
- R10: `abortReq` in idle or done, and `startReq` during a transfer, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Begin a load (sync word then data) |
| abortReq | input | 1 | Request a controlled abort |
| byteTotal | input | CNT_W | Number of data bytes, latched at start |
| inData | input | 8 | Upstream data byte |
| inValid | input | 1 | Upstream byte available |
| inReady | output | 1 | Loader takes the byte this cycle |
| cfgClk | output | 1 | Configuration clock |
| cfgCsN | output | 1 | Active-low chip select |
| cfgWrN | output | 1 | Active-low write |
| cfgData | output | 8 | Configuration data bus |
| done | output | 1 | Transfer of `byteTotal` bytes complete |

## Verification
An abort request and a data handshake can both come due at the same slot boundary. The bench raises `abortReq` while it is still offering a valid byte after a chosen number of accepted bytes. It judges the result in three ways: the accepted count must stop exactly there, the next rising edge must show write high with select low, and select must then rise with `done` low. A second collision comes from pulsing `startReq` in the middle of a stream. This must leave the byte sequence and the edge count unchanged.

// File: rtl/cfgload_pkg.sv
package cfgload_pkg;

  localparam int SYNC_LEN   = 4;
  localparam int SYNC_SEL_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_DATA,
    ST_ABORT,
    ST_DONE
  } loadState_t;

  // strobes from control to the pad datapath
  typedef struct packed {
    logic                  cclkRise;
    logic                  cclkFall;
    logic                  busGrab;
    logic                  busFree;
    logic                  dirFlip;
    logic                  loadSync;
    logic                  loadData;
    logic [SYNC_SEL_W-1:0] syncSel;
  } padCmd_t;

endpackage

// File: rtl/cfgload_ctrl.sv
module cfgload_ctrl
  import cfgload_pkg::*;
#(
  parameter int HALF_DIV = 1,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             abortReq,
  input  logic             inValid,
  input  logic [CNT_W-1:0] byteTotal,
  output logic             inReady,
  output logic             doneFlag,
  output padCmd_t          cmd
);

  localparam int HCW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [HCW-1:0] HALF_LAST = HCW'(HALF_DIV - 1);
  localparam logic [SYNC_SEL_W-1:0] SYNC_LAST = SYNC_SEL_W'(SYNC_LEN - 1);

  loadState_t            state, stateNx;
  logic [CNT_W-1:0]      remain, remNx;
  logic [SYNC_SEL_W-1:0] syncIdx, syncNx;
  logic [HCW-1:0]        halfCnt;
  logic                  slotOn, highPh;
  logic                  launch;
  logic                  halfEnd, slotEnd, midPt, boundary;

  assign halfEnd  = (halfCnt == HALF_LAST);
  assign slotEnd  = slotOn && highPh && halfEnd;
  assign midPt    = slotOn && !highPh && halfEnd;
  assign boundary = !slotOn || slotEnd;

  assign inReady  = boundary && (state == ST_DATA) && !abortReq && (remain != '0);
  assign doneFlag = (state == ST_DONE);

  always_comb begin
    cmd          = '0;
    cmd.cclkRise = midPt;
    cmd.cclkFall = slotEnd;
    cmd.syncSel  = syncIdx;
    stateNx      = state;
    remNx        = remain;
    syncNx       = syncIdx;
    launch       = 1'b0;
    if (boundary) begin
      unique case (state)
        ST_IDLE, ST_DONE: begin
          if (startReq) begin
            cmd.busGrab = 1'b1;
            remNx       = byteTotal;
            syncNx      = '0;
            stateNx     = ST_SYNC;
          end
        end
        ST_SYNC: begin
          if (abortReq) begin
            cmd.dirFlip = 1'b1;
            launch      = 1'b1;
            stateNx     = ST_ABORT;
          end else begin
            cmd.loadSync = 1'b1;
            launch       = 1'b1;
            syncNx       = syncIdx + 1'b1;
            if (syncIdx == SYNC_LAST) stateNx = ST_DATA;
          end
        end
        ST_DATA: begin
          if (abortReq) begin
            cmd.dirFlip = 1'b1;
            launch      = 1'b1;
            stateNx     = ST_ABORT;
          end else if (remain == '0) begin
            cmd.busFree = 1'b1;
            stateNx     = ST_DONE;
          end else if (inValid) begin
            cmd.loadData = 1'b1;
            launch       = 1'b1;
            remNx        = remain - 1'b1;
          end
        end
        ST_ABORT: begin
          cmd.busFree = 1'b1;
          stateNx     = ST_IDLE;
        end
        default: stateNx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      remain  <= '0;
      syncIdx <= '0;
      slotOn  <= 1'b0;
      highPh  <= 1'b0;
      halfCnt <= '0;
    end else begin
      state   <= stateNx;
      remain  <= remNx;
      syncIdx <= syncNx;
      if (launch) begin
        slotOn  <= 1'b1;
        highPh  <= 1'b0;
        halfCnt <= '0;
      end else if (slotEnd) begin
        slotOn  <= 1'b0;
        highPh  <= 1'b0;
        halfCnt <= '0;
      end else if (midPt) begin
        highPh  <= 1'b1;
        halfCnt <= '0;
      end else if (slotOn) begin
        halfCnt <= halfCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cfgload_pads.sv
module cfgload_pads
  import cfgload_pkg::*;
#(
  parameter int                         BYTE_W    = 8,
  parameter logic [SYNC_LEN*BYTE_W-1:0] SYNC_WORD = 32'hC3A5_5A3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  padCmd_t           cmd,
  input  logic [BYTE_W-1:0] inData,
  output logic              cfgClk,
  output logic              cfgCsN,
  output logic              cfgWrN,
  output logic [BYTE_W-1:0] cfgData
);

  logic [BYTE_W-1:0] syncBytes [SYNC_LEN];

  for (genvar k = 0; k < SYNC_LEN; k++) begin : g_sync
    assign syncBytes[k] = SYNC_WORD[(SYNC_LEN-1-k)*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgClk  <= 1'b0;
      cfgCsN  <= 1'b1;
      cfgWrN  <= 1'b1;
      cfgData <= '0;
    end else begin
      if (cmd.cclkRise)      cfgClk <= 1'b1;
      else if (cmd.cclkFall) cfgClk <= 1'b0;

      if (cmd.busGrab) begin
        cfgCsN <= 1'b0;
        cfgWrN <= 1'b0;
      end else if (cmd.busFree) begin
        cfgCsN <= 1'b1;
        cfgWrN <= 1'b1;
      end else if (cmd.dirFlip) begin
        cfgWrN <= 1'b1;
      end

      if (cmd.loadSync)      cfgData <= syncBytes[cmd.syncSel];
      else if (cmd.loadData) cfgData <= inData;
    end
  end

endmodule

// File: rtl/slave_cfg_loader.sv
module slave_cfg_loader
  import cfgload_pkg::*;
#(
  parameter int                  HALF_DIV  = 1,
  parameter int                  CNT_W     = 16,
  parameter int                  BYTE_W    = 8,
  parameter logic [SYNC_LEN*BYTE_W-1:0] SYNC_WORD = 32'hC3A5_5A3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              abortReq,
  input  logic [CNT_W-1:0]  byteTotal,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  output logic              cfgClk,
  output logic              cfgCsN,
  output logic              cfgWrN,
  output logic [BYTE_W-1:0] cfgData,
  output logic              done
);

  padCmd_t cmd;

  cfgload_ctrl #(
    .HALF_DIV (HALF_DIV),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .abortReq  (abortReq),
    .inValid   (inValid),
    .byteTotal (byteTotal),
    .inReady   (inReady),
    .doneFlag  (done),
    .cmd       (cmd)
  );

  cfgload_pads #(
    .BYTE_W    (BYTE_W),
    .SYNC_WORD (SYNC_WORD)
  ) u_pads (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .inData  (inData),
    .cfgClk  (cfgClk),
    .cfgCsN  (cfgCsN),
    .cfgWrN  (cfgWrN),
    .cfgData (cfgData)
  );

endmodule

// File: rtl/cfgload_chk.sv
module cfgload_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic [BYTE_W-1:0] inData,
  input logic              cfgClk,
  input logic              cfgCsN,
  input logic              cfgWrN,
  input logic [BYTE_W-1:0] cfgData,
  input logic              done
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgCsN |-> (!cfgClk && !inReady));

  // R2
  grab_together_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cfgCsN) |-> (!cfgWrN && !cfgClk));

  // R4
  accept_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (cfgData == $past(inData)));

  // R4
  data_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgClk) |-> ($stable(cfgData) && !cfgCsN));

  // R4
  ready_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (!cfgCsN && !cfgWrN));

  // R7
  done_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cfgCsN && cfgWrN && !cfgClk));

  // R8
  abort_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(cfgWrN) && !cfgCsN) |-> !cfgClk);

endmodule

bind slave_cfg_loader cfgload_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .inReady (inReady),
  .inData  (inData),
  .cfgClk  (cfgClk),
  .cfgCsN  (cfgCsN),
  .cfgWrN  (cfgWrN),
  .cfgData (cfgData),
  .done    (done)
);

// File: tb/slave_cfg_loader_test.sv
module slave_cfg_loader_test;

  localparam logic [31:0] SYNC = 32'hC3A5_5A3C;
  localparam logic [7:0]  NO_ABORT   = 8'd255;
  localparam logic [7:0]  SYNC_ABORT = 8'd200;

  typedef struct packed {
    logic [15:0] n;
    logic [7:0]  stall;
    logic [7:0]  abortAt;
    logic [7:0]  gap;
    logic        poke;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{16'd5, 8'd0, NO_ABORT,   8'd0,  1'b0},
    '{16'd9, 8'd3, NO_ABORT,   8'd0,  1'b0},
    '{16'd0, 8'd0, NO_ABORT,   8'd0,  1'b0},
    '{16'd6, 8'd0, 8'd2,       8'd0,  1'b0},
    '{16'd4, 8'd0, NO_ABORT,   8'd20, 1'b0},
    '{16'd3, 8'd0, SYNC_ABORT, 8'd0,  1'b0},
    '{16'd7, 8'd2, NO_ABORT,   8'd0,  1'b1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        abortReq = 1'b0;
  logic [15:0] byteTotal = '0;
  logic [7:0]  inData = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic        cfgClk, cfgCsN, cfgWrN, done;
  logic [7:0]  cfgData;

  int total = 0;
  int bad = 0;
  bit prevAborted = 1'b0;

  always #2.5 clk = ~clk;

  slave_cfg_loader #(
    .HALF_DIV  (1),
    .CNT_W     (16),
    .BYTE_W    (8),
    .SYNC_WORD (SYNC)
  ) uut (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .abortReq  (abortReq),
    .byteTotal (byteTotal),
    .inData    (inData),
    .inValid   (inValid),
    .inReady   (inReady),
    .cfgClk    (cfgClk),
    .cfgCsN    (cfgCsN),
    .cfgWrN    (cfgWrN),
    .cfgData   (cfgData),
    .done      (done)
  );

  function automatic logic [7:0] patByte(input int n, input int i);
    return 8'(i * 37 + n * 11 + 3);
  endfunction

  function automatic logic [7:0] syncByte(input int k);
    return SYNC[31 - 8*k -: 8];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic runCase(input vec_t v);
    int  n, sent, rises, cyc, lastRise, abortRise, syncBad, dataBad, spaceBad;
    int  sAct, sExp, dAct, dExp;
    bit  pend, prevC, abortSeen, finished, csBad, quietOk, doAbort, syncMode;
    n = int'(v.n);
    sent = 0; rises = 0; cyc = 0; lastRise = 0; abortRise = -1;
    syncBad = 0; dataBad = 0; spaceBad = 0; sAct = 0; sExp = 0; dAct = 0; dExp = 0;
    pend = 0; prevC = 0; abortSeen = 0; finished = 0; csBad = 0; quietOk = 1;
    doAbort  = (v.abortAt != NO_ABORT);
    syncMode = (v.abortAt == SYNC_ABORT);
    byteTotal = v.n;
    @(negedge clk);
    startReq = 1'b1;
    while (!finished && cyc < 400) begin
      @(negedge clk);
      cyc++;
      startReq = v.poke && (cyc == 12);
      if (pend) begin sent++; pend = 0; end
      inValid = (sent < n) && (cyc > int'(v.gap)) &&
                !(v.stall != 0 && (cyc % int'(v.stall)) == 0);
      inData = patByte(n, sent);
      abortReq = doAbort && !abortSeen &&
                 (syncMode ? (rises >= 1) : (rises >= 4 && sent == int'(v.abortAt)));
      #1;
      pend = inValid && inReady;
      if (cfgClk && !prevC) begin
        if (!cfgCsN && cfgWrN) begin
          abortSeen = 1;
          abortRise = rises;
          abortReq  = 1'b0;
        end else if (rises < 4) begin
          if (cfgCsN || cfgWrN || cfgData != syncByte(rises)) begin
            if (syncBad == 0) begin sAct = cfgData; sExp = syncByte(rises); end
            syncBad++;
          end
          if (rises >= 1 && cyc - lastRise != 2) spaceBad++;
        end else begin
          if (cfgCsN || cfgWrN || cfgData != patByte(n, rises - 4)) begin
            if (dataBad == 0) begin dAct = cfgData; dExp = patByte(n, rises - 4); end
            dataBad++;
          end
          if (v.stall == 0 && v.gap == 0 && rises > 4 && cyc - lastRise != 2) spaceBad++;
        end
        lastRise = cyc;
        rises++;
      end
      prevC = cfgClk;
      if (rises >= 1 && !done && !abortSeen && cfgCsN) csBad = 1;
      if (v.gap != 0 && cyc == int'(v.gap))
        quietOk = (rises == 4) && !cfgClk && !cfgCsN && !cfgWrN;
      if (done) finished = 1;
      if (abortSeen && cfgCsN) finished = 1;
    end
    abortReq = 1'b0;
    inValid  = 1'b0;
    startReq = 1'b0;

    chk(finished == 1, doAbort ? "R8" : "R7", "transfer ended", finished, 1);
    chk(syncBad == 0, prevAborted ? "R9" : "R3", "sync byte", sAct, sExp);
    chk(dataBad == 0, "R4", "data byte", dAct, dExp);
    chk(spaceBad == 0, "R6", "cclk spacing errors", spaceBad, 0);
    chk(!csBad, "R2", "select held low", csBad, 0);
    if (v.gap != 0) chk(quietOk, "R5", "clock parked during stall", quietOk, 1);
    if (doAbort) begin
      chk(abortSeen, "R8", "abort edge seen", abortSeen, 1);
      chk(!done && cfgCsN && cfgWrN, "R8", "released after abort", {done, cfgCsN, cfgWrN}, 3'b011);
      chk(rises == abortRise + 1, "R8", "edges after abort", rises, abortRise + 1);
      if (!syncMode) chk(sent == int'(v.abortAt), "R8", "bytes accepted", sent, v.abortAt);
      else chk(abortRise < 4 && sent == 0, "R8", "abort inside sync", abortRise, 3);
    end else begin
      chk(rises == 4 + n, v.poke ? "R10" : "R7", "rising edges", rises, 4 + n);
      chk(sent == n, "R7", "bytes accepted", sent, n);
      chk(done && cfgCsN && cfgWrN, "R7", "done and released", {done, cfgCsN, cfgWrN}, 3'b111);
    end
    prevAborted = doAbort;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(cfgCsN && cfgWrN, "R1", "select/write idle", {cfgCsN, cfgWrN}, 2'b11);
    chk(!cfgClk, "R1", "cclk idle", cfgClk, 0);
    chk(!done && !inReady, "R1", "done/ready idle", {done, inReady}, 2'b00);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk(cfgCsN && !cfgClk && !done, "R1", "idle after reset", {cfgCsN, cfgClk, done}, 3'b100);

    for (int i = 0; i < NVEC; i++) runCase(VECS[i]);

    // R10: abort request in done state is ignored
    begin
      int  riseCnt;
      bit  pc;
      riseCnt = 0;
      pc = cfgClk;
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        abortReq = 1'b1;
        #1;
        if (cfgClk && !pc) riseCnt++;
        pc = cfgClk;
      end
      @(negedge clk);
      abortReq = 1'b0;
      #1;
      chk(riseCnt == 0, "R10", "cclk edges on idle abort", riseCnt, 0);
      chk(done && cfgCsN && cfgWrN, "R10", "done kept", {done, cfgCsN, cfgWrN}, 3'b111);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule